// File: doc/BRIEF.md
# Sinc2 Bitstream Decimator with Fast Start

This block turns the one-bit density stream of a second-order sigma-delta modulator into signed multibit samples through a second-order sinc filter. A two-stage accumulator cascade runs on every modulator clock. A second-order difference stage acts only when an external sample strobe arrives, and it works on the values the cascade holds at each strobe. The strobe timer, the modulator itself and any input multiplexing live outside this block.

The block is built for multiplexed use, where a freshly selected input must produce a good sample quickly. A start pulse discards the capture history. The first strobe after start may come after a short interval, which also gives the modulator time to settle on the new input. That strobe provides the oldest capture. Two strobes at full spacing follow it, and the third capture yields a valid sample. A fresh input is therefore ready after one short interval and two full intervals, where a plain sinc2 filter needs three full intervals. From then on, every strobe yields a new sample. A data-available flag tells the consumer a sample is waiting, and a read pulse clears that flag.

Top module: `sinc2_fast_decim`

## Requirements
- R1: Both accumulators advance on every clock. A bit value of 1 contributes +1 and a bit value of 0 contributes -1. Both accumulators are 2*clog2(MAX_DECIM)+1 bits wide and wrap modulo their width, so the outputs stay exact after the accumulators overflow.
- R2: Call the accumulator-cascade values held just before the last three counted strobe edges c_old, c_mid and c_new. A valid sample equals (c_new - c_mid) - (c_mid - c_old). When both intervals span M clocks, input bit k clocks after the oldest counted strobe edge carries weight min(k+1, 2M-1-k). A constant 1 input gives +M*M and a constant 0 input gives -M*M.
- R3: A start pulse empties the capture history and clears the data-available flag on the next edge. It does not change the sample word or the accumulators.
- R4: After a start, the first and second counted strobes leave the flag at 0. The third counted strobe sets the flag and loads the sample word on that same edge.
- R5: Once three captures are held, every further counted strobe loads a new sample and sets the flag.
- R6: A read pulse clears the flag on the next edge. When a read and a sample-producing strobe fall in the same cycle, the flag stays at 1.
- R7: The sample word changes only on an edge where a sample is produced. It holds through reads and through idle cycles.
- R8: A strobe that falls in the same cycle as a start is not counted.
- R9: Synchronous reset clears the flag, the sample word, the capture history and both accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Modulator bitstream: 1 counts as +1 and 0 counts as -1 |
| strobe | input | 1 | One-cycle sample-rate capture strobe |
| start | input | 1 | One-cycle pulse that restarts the capture sequence |
| rd | input | 1 | One-cycle pulse that consumes the current sample |
| sample_out | output | 2*clog2(MAX_DECIM)+1 | Signed filtered sample |
| data_avail | output | 1 | A valid sample is waiting |

## Verification
The bench builds the block with the default MAX_DECIM of 181, which gives a 17-bit path. With that width the accumulators wrap a few hundred clocks after reset, so every later check also exercises R1. The bench spaces its strobes to give decimation ratios from 5 up to 181. The ratio of 181 with a constant input reaches the full-scale result of ±32761. Short first intervals of 1 to 16 clocks, together with several bit patterns, let the bench compare every sample against the triangular-weight sum it computes itself.

// File: rtl/sinc2_dec_pkg.sv
package sinc2_dec_pkg;

  // How many strobe captures are held since the last start.
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_TWO   = 2'd2,
    FILL_READY = 2'd3
  } fill_t;

  function automatic fill_t fill_next(input fill_t cur);
    case (cur)
      FILL_EMPTY: fill_next = FILL_ONE;
      FILL_ONE:   fill_next = FILL_TWO;
      default:    fill_next = FILL_READY;
    endcase
  endfunction

  function automatic int path_width(input int max_decim);
    path_width = 2 * $clog2(max_decim) + 1;
  endfunction

endpackage

// File: rtl/sinc2_dec_integ.sv
module sinc2_dec_integ #(
  parameter int ACC_W  = 17,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);

  logic [ACC_W-1:0] step;
  assign step = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [ACC_W-1:0] acc_q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) acc_q <= '0;
          else     acc_q <= acc_q + step;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) acc_q <= '0;
          else     acc_q <= acc_q + g_stage[g-1].acc_q;
        end
      end
    end
  endgenerate

  assign acc_out = g_stage[STAGES-1].acc_q;

endmodule

// File: rtl/sinc2_dec_ctrl.sv
module sinc2_dec_ctrl
  import sinc2_dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic strobe,
  input  logic rd,
  output logic cap_en,
  output logic fire,
  output logic data_avail
);

  fill_t fill_q;
  logic  avail_q;

  // A start in the same cycle swallows the strobe.
  assign cap_en = strobe & ~start;
  assign fire   = cap_en & ((fill_q == FILL_TWO) | (fill_q == FILL_READY));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= FILL_EMPTY;
      avail_q <= 1'b0;
    end else begin
      if (start)       fill_q <= FILL_EMPTY;
      else if (cap_en) fill_q <= fill_next(fill_q);

      if (start)     avail_q <= 1'b0;
      else if (fire) avail_q <= 1'b1;
      else if (rd)   avail_q <= 1'b0;
    end
  end

  assign data_avail = avail_q;

endmodule

// File: rtl/sinc2_dec_diff.sv
module sinc2_dec_diff #(
  parameter int ACC_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             fire,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] sample_out
);

  // Only the newest capture and the previous first difference are kept.
  logic [ACC_W-1:0] last_cap_q;
  logic [ACC_W-1:0] last_diff_q;
  logic [ACC_W-1:0] new_diff;
  logic [ACC_W-1:0] sample_q;

  assign new_diff = acc_in - last_cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cap_q  <= '0;
      last_diff_q <= '0;
      sample_q    <= '0;
    end else begin
      if (cap_en) begin
        last_cap_q  <= acc_in;
        last_diff_q <= new_diff;
      end
      if (fire) sample_q <= new_diff - last_diff_q;
    end
  end

  assign sample_out = sample_q;

endmodule

// File: rtl/sinc2_fast_decim.sv
module sinc2_fast_decim
  import sinc2_dec_pkg::*;
#(
  parameter int MAX_DECIM = 181
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                bit_in,
  input  logic                                strobe,
  input  logic                                start,
  input  logic                                rd,
  output logic signed [2*$clog2(MAX_DECIM):0] sample_out,
  output logic                                data_avail
);

  localparam int ACC_W  = path_width(MAX_DECIM);
  localparam int STAGES = 2;

  logic [ACC_W-1:0] cascade;
  logic [ACC_W-1:0] sample_w;
  logic             cap_en;
  logic             fire;

  sinc2_dec_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .acc_out (cascade)
  );

  sinc2_dec_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .strobe     (strobe),
    .rd         (rd),
    .cap_en     (cap_en),
    .fire       (fire),
    .data_avail (data_avail)
  );

  sinc2_dec_diff #(.ACC_W(ACC_W)) u_diff (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .fire       (fire),
    .acc_in     (cascade),
    .sample_out (sample_w)
  );

  assign sample_out = $signed(sample_w);

endmodule

// File: rtl/sinc2_fast_decim_chk.sv
module sinc2_fast_decim_chk #(
  parameter int SW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          strobe,
  input logic          rd,
  input logic [SW-1:0] sample_out,
  input logic          data_avail
);

  // Independent tally of the strobes counted since the last start.
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst || start)                  seen_q <= 2'd0;
    else if (strobe && seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  p_fill_r4: assert property (@(posedge clk) disable iff (rst)
    data_avail |-> seen_q == 2'd3);

  p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> !data_avail);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd && !strobe) |=> !data_avail);

  p_flag_from_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(data_avail) |-> $past(strobe && !start));

  p_sample_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_out) |-> $past(strobe && !start));

endmodule

bind sinc2_fast_decim sinc2_fast_decim_chk #(.SW(2*$clog2(MAX_DECIM)+1)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .strobe     (strobe),
  .rd         (rd),
  .sample_out (sample_out),
  .data_avail (data_avail)
);

// File: tb/sinc2_fast_decim_test.sv
module sinc2_fast_decim_test;

  localparam int MAXD = 181;
  localparam int SW   = 2*$clog2(MAXD)+1;
  localparam int NVEC = 8;
  // pattern, short interval, full interval M, extra samples
  localparam int VEC [NVEC][4] = '{
    '{1, 3,   8, 1},
    '{0, 2,   8, 1},
    '{2, 4,   9, 2},
    '{3, 1,  12, 2},
    '{4, 5,  10, 1},
    '{3, 16, 118, 1},
    '{2, 1,   5, 3},
    '{4, 7,  64, 2}
  };

  logic clk = 1'b0, rst = 1'b1, bit_in = 1'b0;
  logic strobe = 1'b0, start = 1'b0, rd = 1'b0;
  logic signed [SW-1:0] sample_out;
  logic data_avail;

  int cyc = 0, n_chk = 0, n_bad = 0, patsel = 0;
  bit finished = 1'b0;

  sinc2_fast_decim #(.MAX_DECIM(MAXD)) uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .strobe(strobe),
    .start(start), .rd(rd), .sample_out(sample_out), .data_avail(data_avail)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit patbit(input int p, input int k);
    case (p)
      0: patbit = 1'b0;
      1: patbit = 1'b1;
      2: patbit = bit'(k % 2);
      3: patbit = ((k * 5) % 7) < 3;
      default: patbit = bit'((k / 13) % 2);
    endcase
  endfunction

  // Bit sampled at edge index cyc is driven at the preceding negedge.
  always @(negedge clk) bit_in = patbit(patsel, cyc);

  function automatic int expect_val(input int p, input int e0, input int m);
    int s = 0;
    for (int d = 0; d <= 2*m-2; d++) begin
      int w = (d + 1 < 2*m - 1 - d) ? d + 1 : 2*m - 1 - d;
      s += patbit(p, e0 + d) ? w : -w;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; tick(1); strobe = 1'b0;
  endtask

  function automatic int smp();
    return int'(sample_out);
  endfunction

  task automatic conv(input int p, input int sh, input int m, input int extra);
    int e0, held;
    patsel = p;
    start = 1'b1; tick(1); start = 1'b0;
    chk("R3 flag after start", int'(data_avail), 0);
    tick(sh - 1);
    e0 = cyc;
    pulse_strobe();
    chk("R4 flag after first capture", int'(data_avail), 0);
    tick(m - 1); pulse_strobe();
    chk("R4 flag after second capture", int'(data_avail), 0);
    tick(m - 1); pulse_strobe();
    chk("R4 flag after third capture", int'(data_avail), 1);
    chk("R2 R1 first sample", smp(), expect_val(p, e0, m));
    for (int x = 0; x < extra; x++) begin
      held = smp();
      rd = 1'b1; tick(1); rd = 1'b0;
      chk("R6 flag after read", int'(data_avail), 0);
      chk("R7 sample held over read", smp(), held);
      tick(m - 2); pulse_strobe();
      chk("R5 flag on next sample", int'(data_avail), 1);
      chk("R5 R2 next sample", smp(), expect_val(p, e0 + (x + 1) * m, m));
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int held, e0;
    tick(3);
    chk("R9 flag in reset", int'(data_avail), 0);
    chk("R9 sample in reset", smp(), 0);
    rst = 1'b0;
    tick(2);

    for (int i = 0; i < NVEC; i++)
      conv(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // R8: strobe coinciding with start is not counted.
    patsel = 1;
    start = 1'b1; strobe = 1'b1; tick(1); start = 1'b0; strobe = 1'b0;
    tick(2);
    e0 = cyc;
    pulse_strobe(); tick(19); pulse_strobe();
    chk("R8 only two captures counted", int'(data_avail), 0);
    tick(19); pulse_strobe();
    chk("R8 third counted capture valid", int'(data_avail), 1);
    chk("R2 constant ones gives M*M", smp(), 400);
    chk("R2 formula agrees", smp(), expect_val(1, e0, 20));

    // R6: read in the same cycle as a new sample keeps the flag.
    tick(19);
    rd = 1'b1; strobe = 1'b1; tick(1); rd = 1'b0; strobe = 1'b0;
    chk("R6 read with new sample keeps flag", int'(data_avail), 1);

    // R3: start clears the flag but keeps the sample word.
    held = smp();
    start = 1'b1; tick(1); start = 1'b0;
    chk("R3 start clears flag", int'(data_avail), 0);
    chk("R3 start keeps sample", smp(), held);

    // R7: idle cycles leave the sample word unchanged.
    tick(25);
    chk("R7 sample held while idle", smp(), held);

    // R1: full-scale results well after the accumulators have wrapped.
    conv(1, 3, 181, 1);
    chk("R1 full-scale positive", smp(), 181 * 181);
    conv(0, 2, 181, 1);
    chk("R1 full-scale negative", smp(), -(181 * 181));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule